// File: doc/BRIEF.md
# Two-Register Alternating Firmware Download Sequencer

This block streams a firmware image into a target device through a small register-access bus, one 32-bit word at a time. A requester gives the image length in words and pulses `start`. The sequencer opens the target's download window, then writes the words into two data registers in turn. Before each word it waits for that register's own busy flag to clear. After each word it waits a settling time and then raises the matching flag to hand the word over.

After the last word, the sequencer waits for both busy flags to drop and closes the download window. It then polls the target's result field. A field that stays at zero is treated as a load that never finished, and the whole image is sent again, up to a bounded number of times. The image source replays the image from its first word whenever `img_restart` pulses.

All waits are counted in microsecond ticks made by a parameterised clock prescaler, and every poll loop is bounded by a parameterised read count. The requester sees `busy`, a one-cycle `done` and a 2-bit error code. The codes are 0 none, 1 handshake timeout, 2 device error and 3 retries exhausted.

Top module: `fwdl_seq`

## Requirements
- R1: One clock after `start` is sampled in idle, the first bus access is a byte write of 0x01 to address 0xF4 (bit 0 is the enable). This is repeated at the start of every retry.
- R2: Image word i is written as a 32-bit access (`bus_size`=1) to address 0xF8 when i is even and to 0xFC when i is odd.
- R3: Before word i, the sequencer byte-reads 0xF5 until bit (i mod 2) is 0, leaving one tick between reads. If POLL_LIMIT reads in a row all find the bit set, the run ends with err=1 and no further bus write.
- R4: Each word is written unaltered. Bits 7:0 of a word hold the image byte at the lowest address.
- R5: After a data write completes, at least SETTLE_US ticks (SETTLE_US*TICK_DIV clocks) pass. Then a byte write to 0xF5 sets only bit (i mod 2).
- R6: After the last word, 0xF5 is read until bits 1:0 are both 0. If POLL_LIMIT reads go by without that, the sequence continues without error.
- R7: Next comes a byte write of 0x00 to 0xF4, then byte reads of 0xF4 until bit 4 is 1. When bit 4 is seen, the run ends with err=0.
- R8: Suppose POLL_LIMIT reads of 0xF4 pass without bit 4 set, and the last read has bits 6:4 equal to zero. Then `img_restart` pulses and the download restarts from R1. After MAX_RETRY restarts, the next such failure ends the run with err=3.
- R9: If the result poll times out with bits 6:4 nonzero, the run ends with err=2.
- R10: `busy` is 0 in reset and high from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse. `err` holds until the next accepted start. A `start` while busy has no effect.
- R11: A bus request keeps its address, data, direction and size stable until `bus_ack`.
- R12: `wd_ready` is high only while the sequencer waits for the next word. Exactly one word is consumed per index per attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a download (sampled only when idle) |
| img_words | input | LEN_W | Image length in 32-bit words |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 2 | 0 none, 1 handshake timeout, 2 device error, 3 retries exhausted |
| img_restart | output | 1 | Pulse: replay the image from word 0 |
| wd_valid | input | 1 | Image word available |
| wd_data | input | 32 | Image word, lowest-address byte in bits 7:0 |
| wd_ready | output | 1 | Word accepted when high with `wd_valid` |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_size | output | 1 | 1 32-bit access, 0 byte access |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 32 | Write data, bytes in bits 7:0 |
| bus_rdata | input | 8 | Byte read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |

## Verification
The bench builds the sequencer with TICK_DIV=2, POLL_LIMIT=8, SETTLE_US=3 and MAX_RETRY=2. With these values a full handshake timeout, a drain timeout, a result-poll timeout and the whole retry budget each take only tens of cycles. Its target model can hold the busy flags set, keep the result field at zero for a chosen number of attempts, or report a device error. This makes the abort path, the non-fatal drain path, recovery after retries, running out of retries and the error exit all reachable within one short run.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

  localparam logic [7:0] ADDR_CTRL = 8'hF4;
  localparam logic [7:0] ADDR_HS   = 8'hF5;
  localparam logic [7:0] ADDR_D0   = 8'hF8;
  localparam logic [7:0] ADDR_D1   = 8'hFC;

  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_HSRD, S_HSGAP, S_WORD, S_DAT, S_SETTLE, S_SET,
    S_DRRD, S_DRGAP, S_CLR, S_RESRD, S_RESGAP
  } fwdl_state_t;

  typedef enum logic [1:0] {
    E_NONE    = 2'd0,
    E_TIMEOUT = 2'd1,
    E_DEVICE  = 2'd2,
    E_RETRY   = 2'd3
  } fwdl_err_t;

endpackage

// File: rtl/fwdl_rstsync.sv
module fwdl_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fwdl_timer.sv
module fwdl_timer #(
  parameter int TICK_DIV = 100,
  parameter int US_W     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] n_us,
  output logic            idle
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [DIV_W-1:0] RELOAD = DIV_W'(TICK_DIV - 1);

  logic            run_q, run_n;
  logic [US_W-1:0] us_q, us_n;
  logic [DIV_W-1:0] pre_q, pre_n;

  always_comb begin
    run_n = run_q;
    us_n  = us_q;
    pre_n = pre_q;
    if (load) begin
      run_n = 1'b1;
      us_n  = n_us;
      pre_n = RELOAD;
    end else if (run_q) begin
      if (pre_q == '0) begin
        pre_n = RELOAD;
        if (us_q <= US_W'(1)) run_n = 1'b0;
        else                  us_n  = us_q - US_W'(1);
      end else begin
        pre_n = pre_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      us_q  <= '0;
      pre_q <= '0;
    end else begin
      run_q <= run_n;
      us_q  <= us_n;
      pre_q <= pre_n;
    end
  end

  assign idle = !run_q;

  // R5: the prescaler never leaves its tick range
  a_r5_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= RELOAD);
endmodule

// File: rtl/fwdl_pollcnt.sv
module fwdl_pollcnt #(
  parameter int POLL_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  logic [PC_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign last = (cnt_q == PC_W'(POLL_LIMIT - 1));

  // R3: failed reads never pile up past the limit
  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PC_W'(POLL_LIMIT));
endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
  import fwdl_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int POLL_LIMIT = 10000,
  parameter int SETTLE_US  = 100,
  parameter int MAX_RETRY  = 10,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_words,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic             img_restart,
  input  logic             wd_valid,
  input  logic [31:0]      wd_data,
  output logic             wd_ready,
  output logic             bus_req,
  output logic             bus_we,
  output logic             bus_size,
  output logic [7:0]       bus_addr,
  output logic [31:0]      bus_wdata,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_ack
);
  localparam int US_W = $clog2(SETTLE_US + 1);
  localparam int RT_W = $clog2(MAX_RETRY + 2);

  logic srst_n;
  fwdl_state_t state_q, state_n;
  logic [LEN_W-1:0] idx_q, idx_n, len_q, len_n;
  logic [RT_W-1:0]  retry_q, retry_n;
  logic [31:0]      word_q, word_n;
  fwdl_err_t        err_q, err_n;
  logic             done_q, done_n, rsrt_q, rsrt_n;
  logic             pc_clr, pc_inc, pc_last;
  logic             tm_load, tm_idle;
  logic [US_W-1:0]  tm_n;

  fwdl_rstsync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  fwdl_pollcnt #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(srst_n), .clr(pc_clr), .inc(pc_inc), .last(pc_last));

  fwdl_timer #(.TICK_DIV(TICK_DIV), .US_W(US_W)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(tm_load), .n_us(tm_n), .idle(tm_idle));

  // Bus request decode
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_size  = 1'b0;
    bus_addr  = 8'h00;
    bus_wdata = 32'h0;
    unique case (state_q)
      S_EN:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_CTRL; bus_wdata = 32'h1; end
      S_HSRD, S_DRRD: begin bus_req = 1'b1; bus_addr = ADDR_HS; end
      S_DAT:  begin
        bus_req = 1'b1; bus_we = 1'b1; bus_size = 1'b1;
        bus_addr = idx_q[0] ? ADDR_D1 : ADDR_D0; bus_wdata = word_q;
      end
      S_SET:  begin
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_HS;
        bus_wdata = idx_q[0] ? 32'h2 : 32'h1;
      end
      S_CLR:  begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_CTRL; end
      S_RESRD: begin bus_req = 1'b1; bus_addr = ADDR_CTRL; end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    len_n   = len_q;
    retry_n = retry_q;
    word_n  = word_q;
    err_n   = err_q;
    done_n  = 1'b0;
    rsrt_n  = 1'b0;
    pc_clr  = 1'b0;
    pc_inc  = 1'b0;
    tm_load = 1'b0;
    tm_n    = US_W'(1);
    unique case (state_q)
      S_IDLE: if (start) begin
        state_n = S_EN; retry_n = '0; err_n = E_NONE; len_n = img_words;
      end
      S_EN: if (bus_ack) begin
        idx_n = '0; pc_clr = 1'b1;
        state_n = (len_q == '0) ? S_DRRD : S_HSRD;
      end
      S_HSRD: if (bus_ack) begin
        if (!bus_rdata[idx_q[0]]) begin
          pc_clr = 1'b1; state_n = S_WORD;
        end else if (pc_last) begin
          err_n = E_TIMEOUT; done_n = 1'b1; state_n = S_IDLE;
        end else begin
          pc_inc = 1'b1; tm_load = 1'b1; state_n = S_HSGAP;
        end
      end
      S_HSGAP: if (tm_idle) state_n = S_HSRD;
      S_WORD: if (wd_valid) begin word_n = wd_data; state_n = S_DAT; end
      S_DAT: if (bus_ack) begin
        tm_load = 1'b1; tm_n = US_W'(SETTLE_US); state_n = S_SETTLE;
      end
      S_SETTLE: if (tm_idle) state_n = S_SET;
      S_SET: if (bus_ack) begin
        pc_clr = 1'b1;
        if (idx_q == len_q - LEN_W'(1)) state_n = S_DRRD;
        else begin idx_n = idx_q + LEN_W'(1); state_n = S_HSRD; end
      end
      S_DRRD: if (bus_ack) begin
        if (bus_rdata[1:0] == 2'b00 || pc_last) begin
          pc_clr = 1'b1; state_n = S_CLR;
        end else begin
          pc_inc = 1'b1; tm_load = 1'b1; state_n = S_DRGAP;
        end
      end
      S_DRGAP: if (tm_idle) state_n = S_DRRD;
      S_CLR: if (bus_ack) begin pc_clr = 1'b1; state_n = S_RESRD; end
      S_RESRD: if (bus_ack) begin
        if (bus_rdata[4]) begin
          done_n = 1'b1; state_n = S_IDLE;
        end else if (pc_last) begin
          pc_clr = 1'b1;
          if (bus_rdata[6:4] != 3'b000) begin
            err_n = E_DEVICE; done_n = 1'b1; state_n = S_IDLE;
          end else if (retry_q == RT_W'(MAX_RETRY)) begin
            err_n = E_RETRY; done_n = 1'b1; state_n = S_IDLE;
          end else begin
            retry_n = retry_q + RT_W'(1); rsrt_n = 1'b1; state_n = S_EN;
          end
        end else begin
          pc_inc = 1'b1; tm_load = 1'b1; state_n = S_RESGAP;
        end
      end
      S_RESGAP: if (tm_idle) state_n = S_RESRD;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      retry_q <= '0;
      word_q  <= '0;
      err_q   <= E_NONE;
      done_q  <= 1'b0;
      rsrt_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      len_q   <= len_n;
      retry_q <= retry_n;
      if (state_q == S_WORD) word_q <= word_n;
      err_q   <= err_n;
      done_q  <= done_n;
      rsrt_q  <= rsrt_n;
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign img_restart = rsrt_q;
  assign wd_ready    = (state_q == S_WORD);

  // R11: request held steady until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!srst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_we) && $stable(bus_size));
  // R2: wide accesses only go to the two data registers
  a_r2_word_target: assert property (@(posedge clk) disable iff (!srst_n)
    bus_req && bus_size |-> bus_we && (bus_addr == ADDR_D0 || bus_addr == ADDR_D1));
  // R5: a handshake write raises exactly one flag
  a_r5_one_flag: assert property (@(posedge clk) disable iff (!srst_n)
    bus_req && bus_we && bus_addr == ADDR_HS |->
      $countones(bus_wdata[1:0]) == 1 && bus_wdata[31:2] == 30'h0);
  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done);
  // R8: retries stay within budget
  a_r8_retry_bound: assert property (@(posedge clk) disable iff (!srst_n)
    retry_q <= RT_W'(MAX_RETRY));
endmodule

// File: tb/sim_fwdl_seq.sv
module sim_fwdl_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 2, PLIM = 8, SETL = 3, MRET = 2, LW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] img_words = '0;
  logic busy, done, img_restart, wd_valid, wd_ready;
  logic [1:0] err;
  logic [31:0] wd_data;
  logic bus_req, bus_we, bus_size, bus_ack;
  logic [7:0] bus_addr, bus_rdata;
  logic [31:0] bus_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwdl_seq #(.TICK_DIV(TDIV), .POLL_LIMIT(PLIM), .SETTLE_US(SETL),
             .MAX_RETRY(MRET), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_words(img_words),
    .busy(busy), .done(done), .err(err), .img_restart(img_restart),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack));

  int nchk = 0, nfail = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // image source
  logic [31:0] img [8];
  int ptr = 0, cur_len = 0;
  assign wd_valid = ptr < cur_len;
  assign wd_data  = wd_valid ? img[ptr] : 32'h0;
  always @(posedge clk) begin
    if (start && !busy) ptr <= 0;
    else if (img_restart) ptr <= 0;
    else if (wd_valid && wd_ready) ptr <= ptr + 1;
  end

  // target model
  bit dev_stuck = 0, dev_deverr = 0;
  int dev_fail_n = 0, attempts = 0;
  logic en = 0, res_pend = 0;
  logic [1:0] hs = 2'b00;
  logic [2:0] res = 3'b000;
  int hs_age = 0;
  always @(posedge clk) begin
    if (!rst_n) bus_ack <= 1'b0;
    else bus_ack <= bus_req && !bus_ack;
    if (bus_req && !bus_ack)
      bus_rdata <= (bus_addr == 8'hF5) ? {6'b0, hs} : {1'b0, res, 3'b000, en};
    if (bus_req && bus_ack && bus_we && bus_addr == 8'hF5) begin
      hs <= hs | bus_wdata[1:0]; hs_age <= 0;
    end else if (hs != 2'b00 && !dev_stuck) begin
      if (hs_age == 2) hs <= 2'b00; else hs_age <= hs_age + 1;
    end
    res_pend <= 1'b0;
    if (bus_req && bus_ack && bus_we && bus_addr == 8'hF4) begin
      en <= bus_wdata[0];
      if (bus_wdata[0]) begin res <= 3'b000; hs <= 2'b00; attempts <= attempts + 1; end
      else res_pend <= 1'b1;
    end
    if (res_pend)
      res <= dev_deverr ? 3'b010 : (attempts > dev_fail_n ? 3'b001 : 3'b000);
  end

  // scoreboard monitor
  logic [40:0] expq [$];
  int cyc = 0, t_dat = 0, f5_rd = 0, words = 0, restarts = 0;
  always @(negedge clk) begin
    cyc++;
    if (wd_valid && wd_ready) words++;
    if (img_restart) restarts++;
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        if (expq.size() == 0)
          check(0, "R1 unexpected write", {bus_size, bus_addr, bus_wdata}, 0);
        else begin
          logic [40:0] e;
          e = expq.pop_front();
          check({bus_size, bus_addr, bus_wdata} == e, "R2/R4 write sequence",
                {bus_size, bus_addr, bus_wdata}, e);
        end
        if (bus_size) t_dat = cyc;
        if (bus_addr == 8'hF5)
          check(cyc - t_dat >= SETL*TDIV, "R5 settle gap", cyc - t_dat, SETL*TDIV);
      end else if (bus_addr == 8'hF5) f5_rd++;
    end
  end

  task automatic push_w(input logic sz, input logic [7:0] a, input logic [31:0] d);
    expq.push_back({sz, a, d});
  endtask
  task automatic exp_seq(input int upto, input bit tail);
    push_w(1'b0, 8'hF4, 32'h1);
    for (int i = 0; i < upto; i++) begin
      push_w(1'b1, (i % 2) ? 8'hFC : 8'hF8, img[i]);
      push_w(1'b0, 8'hF5, (i % 2) ? 32'h2 : 32'h1);
    end
    if (tail) push_w(1'b0, 8'hF4, 32'h0);
  endtask

  int b_att, b_f5, b_wd, b_rs;
  task automatic run(input int len, input bit stuck, input int fail_n, input bit deverr,
                     input bit extra_start);
    dev_stuck = stuck; dev_fail_n = fail_n; dev_deverr = deverr;
    b_att = attempts; b_f5 = f5_rd; b_wd = words; b_rs = restarts;
    cur_len = len; img_words = LW'(len);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R10 busy after start", busy, 1);
    if (extra_start) begin
      repeat (10) @(negedge clk);
      img_words = 8'd1; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0, "R10 idle at done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R1 all expected writes seen", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) img[k] = 32'h0403_0201 + 32'h0404_0404 * k;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10 reset busy", busy, 0);
    check(done === 1'b0, "R10 reset done", done, 0);
    check(err === 2'd0, "R10 reset err", err, 0);
    check(bus_req === 1'b0, "R11 reset bus idle", bus_req, 0);
    check(wd_ready === 1'b0, "R12 reset not ready", wd_ready, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // normal five-word load, stray start mid-run
    exp_seq(5, 1); run(5, 0, 0, 0, 1);
    check(err === 2'd0, "R7 success", err, 0);
    check(attempts - b_att == 1, "R10 stray start ignored", attempts - b_att, 1);
    check(words - b_wd == 5, "R12 words consumed", words - b_wd, 5);
    check(err === 2'd0, "R10 err holds", err, 0);

    // single word boundary
    exp_seq(1, 1); run(1, 0, 0, 0, 0);
    check(err === 2'd0, "R7 single word", err, 0);

    // handshake stuck: third word times out
    exp_seq(2, 0); run(4, 1, 0, 0, 0);
    check(err === 2'd1, "R3 timeout code", err, 1);
    check(f5_rd - b_f5 == 2 + PLIM, "R3 poll count", f5_rd - b_f5, 2 + PLIM);

    // drain stuck is only a warning
    exp_seq(2, 1); run(2, 1, 0, 0, 0);
    check(err === 2'd0, "R6 drain timeout continues", err, 0);
    check(f5_rd - b_f5 == 2 + PLIM, "R6 drain poll count", f5_rd - b_f5, 2 + PLIM);

    // two failures then success
    exp_seq(3, 1); exp_seq(3, 1); exp_seq(3, 1);
    run(3, 0, attempts + 2, 0, 0);
    check(err === 2'd0, "R8 recovered", err, 0);
    check(restarts - b_rs == 2, "R8 restart pulses", restarts - b_rs, 2);
    check(words - b_wd == 9, "R12 replayed words", words - b_wd, 9);

    // never succeeds
    exp_seq(2, 1); exp_seq(2, 1); exp_seq(2, 1);
    run(2, 0, 1000, 0, 0);
    check(err === 2'd3, "R8 retries exhausted", err, 3);
    check(attempts - b_att == MRET + 1, "R8 attempt count", attempts - b_att, MRET + 1);

    // device error code
    exp_seq(2, 1); run(2, 0, 0, 1, 0);
    check(err === 2'd2, "R9 device error", err, 2);
    check(restarts - b_rs == 0, "R9 no restart", restarts - b_rs, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule